// File: doc/BRIEF.md
# Pipelined Store Tag-Check Unit

This block is the store path of a small direct-mapped cache with one-word lines. Each store is split over two cycles. In the first cycle, when the store is accepted, only its tag is checked. In the second step the data array is written, and that write happens in the same cycle that the next store is tag-checked. Between the two steps, the store that hit waits in a one-entry delayed write buffer that holds its full address and data word. Loads, idle cycles and other traffic between two stores leave that pending write in the buffer.

Loads check the tag array in the same way. They also compare their address with the buffer. When the address matches, the load returns the buffered word with the usual one-cycle latency and leaves the buffer in place. A miss of either kind stops the pipeline. In the cycle the miss is seen, the pending write is committed to the data array. The unit then raises a fill request and waits for a fill word from an external engine, which installs the line. A store miss installs its own data word directly and never enters the buffer.

Top module: `store_tagcheck_pipe`

## Requirements
- R1: After reset, `req_ready` is 1, `fill_req` is 0, `rsp_valid` is 0, and every line is invalid, so the first access to any address misses.
- R2: The cache uses index = `req_addr[IDX_W-1:0]` and tag = the remaining upper bits. A load that hits while `req_ready` is 1 gives `rsp_valid`=1 one cycle after acceptance, with the word last written to that address.
- R3: A store that hits is accepted without a stall: `req_ready` stays 1 and `fill_req` stays 0 in the following cycle.
- R4: A load whose address equals the pending buffered store returns that store's data, with the same one-cycle latency as any other hit.
- R5: A store that hits commits the previously pending store to the data array in the same cycle, so later loads to both addresses return both stored words.
- R6: Idle cycles and loads between two stores do not disturb the pending write. Its data is still returned after any number of such cycles.
- R7: On a miss, from the next cycle `req_ready` is 0, `fill_req` is 1 and `fill_addr` equals the missing address, held stable until a cycle with `fill_valid`=1. Requests are ignored while `fill_req` is 1.
- R8: For a load miss, the cycle with `fill_valid`=1 installs the line with `fill_data`, and `rsp_valid`=1 with `rsp_data`=`fill_data` follows one cycle later. A later load to that address hits.
- R9: A store miss installs the line with the store's own data and ignores `fill_data`. A later load to that address returns the store data.
- R10: Any pending write is committed before a fill. A pending write to the very index being refilled cannot overwrite the fill, and a pending write to another index survives the miss.
- R11: Stores never produce `rsp_valid`, whether they hit or miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| req_ready | output | 1 | Request accepted this cycle when high |
| rsp_valid | output | 1 | Load data valid |
| rsp_data | output | DATA_W | Load data |
| fill_req | output | 1 | Miss outstanding, fill wanted |
| fill_addr | output | ADDR_W | Address of the missing word |
| fill_valid | input | 1 | Fill word present |
| fill_data | input | DATA_W | Fill word |

## Verification
The bench targets a load of the buffered address right after the store. A design without forwarding would return the stale array word there. It also places idle cycles and unrelated loads between stores, which would expose a buffer that is lost or committed to the wrong line. The sharpest case is a pending store followed by a miss to the same index with a different tag: if the drain happened after the fill, or never happened, the refilled word would later read back as the old store data. Store misses are checked to install their own data rather than the fill word, and to produce no response.

// File: rtl/stpipe_pkg.sv
package stpipe_pkg;
    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_FILL = 1'b1
    } stp_state_e;
endpackage

// File: rtl/stp_tag_store.sv
module stp_tag_store #(
    parameter int IDX_W = 3,
    parameter int TAG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             hit,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    localparam int LINES = 1 << IDX_W;

    logic [TAG_W-1:0] tag_q [LINES];
    logic [TAG_W-1:0] tag_d [LINES];
    logic [LINES-1:0] vld_q, vld_d;

    always_comb begin
        tag_d = tag_q;
        vld_d = vld_q;
        if (wr_en) begin
            tag_d[wr_idx] = wr_tag;
            vld_d[wr_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
        end else begin
            vld_q <= vld_d;
            tag_q <= tag_d;
        end
    end

    assign hit = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
endmodule

// File: rtl/stp_data_store.sv
module stp_data_store #(
    parameter int IDX_W  = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int LINES = 1 << IDX_W;

    logic [DATA_W-1:0] mem_q [LINES];
    logic [DATA_W-1:0] mem_d [LINES];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) mem_d[wr_idx] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/stp_write_buf.sv
module stp_write_buf #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set,
    input  logic              clear,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic [DATA_W-1:0] set_data,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              valid,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data,
    output logic              match
);
    typedef struct packed {
        logic              v;
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] d;
    } ent_t;

    ent_t ent_q, ent_d;

    always_comb begin
        ent_d = ent_q;
        if (set) begin
            ent_d.v = 1'b1;
            ent_d.a = set_addr;
            ent_d.d = set_data;
        end else if (clear) begin
            ent_d.v = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    assign valid = ent_q.v;
    assign addr  = ent_q.a;
    assign data  = ent_q.d;
    assign match = ent_q.v && (ent_q.a == probe_addr);
endmodule

// File: rtl/store_tagcheck_pipe.sv
module store_tagcheck_pipe #(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data
);
    import stpipe_pkg::*;

    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        stp_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic              rv;
        logic [DATA_W-1:0] rd;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic              tag_hit;
    logic              tw_en;
    logic              dw_en;
    logic [IDX_W-1:0]  dw_idx;
    logic [DATA_W-1:0] dw_data;
    logic [DATA_W-1:0] dr_data;
    logic              wb_set, wb_clr;
    logic              wb_valid, wb_match;
    logic [ADDR_W-1:0] wb_addr;
    logic [DATA_W-1:0] wb_data;

    stp_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (req_addr[IDX_W-1:0]),
        .rd_tag (req_addr[ADDR_W-1:IDX_W]),
        .hit    (tag_hit),
        .wr_en  (tw_en),
        .wr_idx (ctl_q.addr[IDX_W-1:0]),
        .wr_tag (ctl_q.addr[ADDR_W-1:IDX_W])
    );

    stp_data_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (req_addr[IDX_W-1:0]),
        .rd_data (dr_data),
        .wr_en   (dw_en),
        .wr_idx  (dw_idx),
        .wr_data (dw_data)
    );

    stp_write_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .set        (wb_set),
        .clear      (wb_clr),
        .set_addr   (req_addr),
        .set_data   (req_wdata),
        .probe_addr (req_addr),
        .valid      (wb_valid),
        .addr       (wb_addr),
        .data       (wb_data),
        .match      (wb_match)
    );

    // Next-state logic: tag check in RUN, commit of the buffered store
    // overlapped with it, and a stall-and-fill in FILL.
    always_comb begin
        ctl_d   = ctl_q;
        ctl_d.rv = 1'b0;
        tw_en   = 1'b0;
        dw_en   = 1'b0;
        dw_idx  = wb_addr[IDX_W-1:0];
        dw_data = wb_data;
        wb_set  = 1'b0;
        wb_clr  = 1'b0;
        case (ctl_q.st)
            ST_RUN: begin
                if (req_valid) begin
                    if (tag_hit) begin
                        if (req_write) begin
                            dw_en  = wb_valid;
                            wb_set = 1'b1;
                        end else begin
                            ctl_d.rv = 1'b1;
                            ctl_d.rd = wb_match ? wb_data : dr_data;
                        end
                    end else begin
                        // empty the pipeline before the line is replaced
                        dw_en       = wb_valid;
                        wb_clr      = 1'b1;
                        ctl_d.st    = ST_FILL;
                        ctl_d.addr  = req_addr;
                        ctl_d.wr    = req_write;
                        ctl_d.wdata = req_wdata;
                    end
                end
            end
            ST_FILL: begin
                if (fill_valid) begin
                    tw_en    = 1'b1;
                    dw_en    = 1'b1;
                    dw_idx   = ctl_q.addr[IDX_W-1:0];
                    dw_data  = ctl_q.wr ? ctl_q.wdata : fill_data;
                    ctl_d.st = ST_RUN;
                    if (!ctl_q.wr) begin
                        ctl_d.rv = 1'b1;
                        ctl_d.rd = fill_data;
                    end
                end
            end
            default: ctl_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign req_ready = (ctl_q.st == ST_RUN);
    assign fill_req  = (ctl_q.st == ST_FILL);
    assign fill_addr = ctl_q.addr;
    assign rsp_valid = ctl_q.rv;
    assign rsp_data  = ctl_q.rd;
endmodule

// File: rtl/store_tagcheck_chk.sv
module store_tagcheck_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              fill_req,
    input logic              fill_valid,
    input logic [ADDR_W-1:0] fill_addr,
    input logic              buf_valid
);
    // R7: an outstanding fill request holds with a steady address
    p_fill_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req && !fill_valid |=> fill_req && $stable(fill_addr));

    // R7: no request is taken while a fill is outstanding
    p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> !req_ready);

    // R2, R8: a response follows an accepted load or a completed fill
    p_rsp_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(req_valid && req_ready && !req_write)
                       || $past(fill_req && fill_valid)));

    // R11: an accepted store is never answered
    p_store_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_write |=> !rsp_valid);

    // R10: the delayed write buffer is empty while a fill is pending
    p_empty_on_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> !buf_valid);
endmodule

bind store_tagcheck_pipe store_tagcheck_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .fill_req   (fill_req),
    .fill_valid (fill_valid),
    .fill_addr  (fill_addr),
    .buf_valid  (wb_valid)
);

// File: tb/store_tagcheck_pipe_test.sv
`timescale 1ns/1ps
module store_tagcheck_pipe_test;
    localparam int AW = 8;
    localparam int IW = 3;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid, fill_req;
    logic [DW-1:0] rsp_data;
    logic [AW-1:0] fill_addr;
    logic          fill_valid = 1'b0;
    logic [DW-1:0] fill_data = '0;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    logic [DW-1:0]    m_val [256];
    logic [AW-IW-1:0] m_tag [8];
    bit               m_vld [8];
    bit               m_busy = 0;
    logic [AW-1:0]    m_addr;
    bit               m_wr;
    logic [DW-1:0]    m_wd;

    always #2 clk = ~clk;

    store_tagcheck_pipe #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .fill_req(fill_req), .fill_addr(fill_addr),
        .fill_valid(fill_valid), .fill_data(fill_data)
    );

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // One clock of stimulus against the model, entered just after a falling edge.
    task automatic step(input bit v, input bit w, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input bit fv,
                        input logic [DW-1:0] fd, input string rq);
        bit            exp_rv = 0;
        logic [DW-1:0] exp_rd = '0;
        chk(rq, "req_ready", {31'b0, req_ready}, {31'b0, !m_busy});
        chk(rq, "fill_req", {31'b0, fill_req}, {31'b0, m_busy});
        if (m_busy) chk(rq, "fill_addr", {24'b0, fill_addr}, {24'b0, m_addr});
        req_valid = v; req_write = w; req_addr = a; req_wdata = d;
        fill_valid = fv; fill_data = fd;
        if (!m_busy && v) begin
            if (m_vld[a[IW-1:0]] && m_tag[a[IW-1:0]] == a[AW-1:IW]) begin
                if (w) m_val[a] = d;
                else begin exp_rv = 1; exp_rd = m_val[a]; end
            end else begin
                m_busy = 1; m_addr = a; m_wr = w; m_wd = d;
            end
        end else if (m_busy && fv) begin
            m_vld[m_addr[IW-1:0]] = 1;
            m_tag[m_addr[IW-1:0]] = m_addr[AW-1:IW];
            m_val[m_addr] = m_wr ? m_wd : fd;
            if (!m_wr) begin exp_rv = 1; exp_rd = fd; end
            m_busy = 0;
        end
        @(posedge clk);
        #1;
        chk(rq, "rsp_valid", {31'b0, rsp_valid}, {31'b0, exp_rv});
        if (exp_rv) chk(rq, "rsp_data", {16'b0, rsp_data}, {16'b0, exp_rd});
        @(negedge clk);
        req_valid = 0; fill_valid = 0;
    endtask

    task automatic ld(input logic [AW-1:0] a, input string rq);
        step(1, 0, a, '0, 0, '0, rq);
    endtask
    task automatic st(input logic [AW-1:0] a, input logic [DW-1:0] d, input string rq);
        step(1, 1, a, d, 0, '0, rq);
    endtask
    task automatic idle(input string rq);
        step(0, 0, '0, '0, 0, '0, rq);
    endtask
    task automatic fill(input logic [DW-1:0] fd, input string rq);
        step(0, 0, '0, '0, 1, fd, rq);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) m_val[i] = '0;
        for (int i = 0; i < 8; i++) begin m_vld[i] = 0; m_tag[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle state after reset, first access misses
        idle("R1");
        ld(8'h10, "R1");
        idle("R7");                 // fill outstanding, nothing returned
        step(1, 1, 8'h55, 16'hBEEF, 0, '0, "R7"); // request ignored during fill
        fill(16'hAAAA, "R8");
        ld(8'h10, "R2");            // hit on installed line
        // R9 / R11: store miss installs its own word, no response
        st(8'h21, 16'h1111, "R11");
        fill(16'hDEAD, "R9");
        ld(8'h21, "R9");
        // R3 / R4: buffered store forwarded to a following load
        st(8'h10, 16'h5555, "R3");
        ld(8'h10, "R4");
        // R6: idle cycles and loads leave the pending store alone
        idle("R6"); idle("R6"); idle("R6");
        ld(8'h21, "R6");
        ld(8'h10, "R6");
        // R5: next store commits the pending one
        st(8'h21, 16'h2222, "R5");
        ld(8'h10, "R5");
        ld(8'h21, "R4");
        // R10: pending store to the same index as a refilled miss
        ld(8'h29, "R10");
        fill(16'h2929, "R10");
        ld(8'h29, "R10");
        ld(8'h21, "R10");           // evicted, must miss
        fill(16'h7777, "R10");
        ld(8'h21, "R10");
        // R10: pending store to another index survives a miss
        st(8'h10, 16'h6666, "R10");
        ld(8'h33, "R10");
        fill(16'h3333, "R10");
        ld(8'h10, "R10");
        ld(8'h33, "R2");
        // back-to-back store hits then reads
        st(8'h10, 16'h0101, "R3");
        st(8'h33, 16'h0303, "R3");
        st(8'h10, 16'h1010, "R5");
        ld(8'h10, "R4");
        ld(8'h33, "R5");
        idle("R11");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule